// File: doc/BRIEF.md
# Interrupt Source Controller with Auto-Clear

This block gathers interrupt events from a card-side system agent and turns them into per-vector interrupt requests. Twelve event inputs come in: four doorbells and eight DMA channels. Each event sets a sticky bit in a source status word. An enable word masks the status. A bank of mapping words, one per message vector, chooses which sources drive each vector. When a vector has an enabled, mapped, pending source, it emits a one-cycle request pulse. The vector then stays pending until the service side acknowledges it, or until software flushes all pending vectors.

Software reaches the block through a flat 32-bit register port. Writes are single-cycle strobes. Reads are combinational on the address. Enable bits are set by read-modify-write of the enable word and cleared through a separate write-only clear word. Status bits are acknowledged by writing ones back to them. An auto-clear word can make selected status bits drop by themselves once their vector has fired. This applies only while the `multi_vec` input says more than one vector is in use.

Each vector runs a small state machine with three states:
- VS_IDLE: no request outstanding.
- VS_FIRE: the request pulse cycle.
- VS_WAIT: the request is pending service.

Its transitions are:
- T_HIT (VS_IDLE to VS_FIRE): taken when the vector has a live source.
- T_SENT (VS_FIRE to VS_WAIT): always taken after one cycle.
- T_SERVICED (VS_WAIT to VS_IDLE): taken on an acknowledge.
- T_FLUSH (any state to VS_IDLE): taken on a pending-flush write and overrides the others.

Register map (byte addresses):

| Address | Register | Access |
|---------|----------|--------|
| 0x00 | status | read / write-one-to-clear |
| 0x04 | enable | read/write |
| 0x08 | enable-clear | write-only |
| 0x0C | auto-clear | read/write |
| 0x10 | pending flush | write-only, bit 0 |
| 0x40 + 4*v | map word of vector v | read/write |

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_pulse` and `irq_pend` are all 0.
- R2: Doorbell input i sets status bit i, and DMA input j sets status bit 4+j, in the cycle after the event whether or not the source is enabled. Status bits stay set until they are cleared.
- R3: The enable word at 0x04 reads back what was written to its low 12 bits. Each 1 written to the enable-clear word at 0x08 clears the matching enable bit and leaves the others alone. The enable-clear word reads 0.
- R4: Writing a mask to status at 0x00 clears exactly the status bits that are 1 in the mask. A status write never sets a bit.
- R5: When a source event arrives in the same cycle as a write that clears its status bit, the bit stays set.
- R6: When (status AND enable AND map[v]) becomes nonzero with vector v in VS_IDLE, `irq_pulse[v]` is high for exactly the next cycle, and `irq_pend[v]` is high from that cycle on. No further pulse occurs on v while it stays pending. Other vectors do not pulse.
- R7: An acknowledge on `vec_ack[v]` while v is pending and not pulsing returns v to idle in the next cycle. If the source is still live, v pulses again one cycle later.
- R8: With `multi_vec`=1, the status bits that are set in both the auto-clear word at 0x0C and map[v] clear at the end of v's pulse cycle.
- R9: With `multi_vec`=0, the auto-clear word has no effect, and status bits stay set after the pulse.
- R10: Writing 1 to bit 0 of the flush word at 0x10 drops every vector to idle in the next cycle.
- R11: The map word of vector v at 0x40+4*v reads back its low 12 bits. Bits 31:12 read 0. Unassigned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_evt | input | 4 | Doorbell event strobes |
| dma_evt | input | 8 | DMA channel event strobes |
| multi_vec | input | 1 | 1 when more than one vector is in use; gates auto-clear |
| vec_ack | input | 4 | Per-vector service acknowledge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational on addr |
| irq_pulse | output | 4 | Per-vector one-cycle request pulse |
| irq_pend | output | 4 | Per-vector request outstanding |

## Verification
The assertions assume that `addr` is word-aligned on every write, and that the wider bus parameters cover the twelve source bits. They also assume the service side raises `vec_ack` only while the vector is pending. The directed stimulus writes only to listed register addresses. It raises acknowledges only after it has seen the pulse for that vector, and it changes inputs only on the falling clock edge. Before each scenario, the stimulus clears status and flushes all vectors, so no scenario starts with a stale request.

// File: rtl/isc_pkg.sv
package isc_pkg;
    typedef enum logic [1:0] {
        VS_IDLE = 2'd0,
        VS_FIRE = 2'd1,
        VS_WAIT = 2'd2
    } vec_state_e;

    localparam int unsigned OFS_STATUS = 32'h00;
    localparam int unsigned OFS_ENABLE = 32'h04;
    localparam int unsigned OFS_EN_CLR = 32'h08;
    localparam int unsigned OFS_AUTOCL = 32'h0C;
    localparam int unsigned OFS_FLUSH  = 32'h10;
    localparam int unsigned OFS_MAP0   = 32'h40;
    localparam int unsigned MAP_STRIDE = 4;
endpackage

// File: rtl/isc_regs.sv
module isc_regs
    import isc_pkg::*;
#(
    parameter int NSRC   = 12,
    parameter int NVEC   = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NSRC-1:0]            src_evt,
    input  logic [NSRC-1:0]            ac_kill,
    output logic [NSRC-1:0]            status_q,
    output logic [NSRC-1:0]            enable_q,
    output logic [NSRC-1:0]            autocl_q,
    output logic [NVEC-1:0][NSRC-1:0]  map_q,
    output logic                       flush,
    output logic [DATA_W-1:0]          rdata
);
    logic wr_stat, wr_en_reg, wr_enclr, wr_ac;
    logic [NSRC-1:0] wbits, w1c;
    logic [NVEC-1:0] wr_map;

    assign wbits     = wdata[NSRC-1:0];
    assign wr_stat   = wr_en && (addr == ADDR_W'(OFS_STATUS));
    assign wr_en_reg = wr_en && (addr == ADDR_W'(OFS_ENABLE));
    assign wr_enclr  = wr_en && (addr == ADDR_W'(OFS_EN_CLR));
    assign wr_ac     = wr_en && (addr == ADDR_W'(OFS_AUTOCL));
    assign flush     = wr_en && (addr == ADDR_W'(OFS_FLUSH)) && wdata[0];
    assign w1c       = wr_stat ? wbits : '0;

    // Events win over both acknowledge and auto-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            autocl_q <= '0;
        end else begin
            status_q <= (status_q & ~w1c & ~ac_kill) | src_evt;
            if (wr_en_reg)
                enable_q <= wbits;
            else if (wr_enclr)
                enable_q <= enable_q & ~wbits;
            if (wr_ac)
                autocl_q <= wbits;
        end
    end

    for (genvar v = 0; v < NVEC; v++) begin : g_map
        assign wr_map[v] = wr_en && (addr == ADDR_W'(OFS_MAP0 + MAP_STRIDE * v));
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[v] <= '0;
            else if (wr_map[v])
                map_q[v] <= wbits;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STATUS)) rdata = DATA_W'(status_q);
        if (addr == ADDR_W'(OFS_ENABLE)) rdata = DATA_W'(enable_q);
        if (addr == ADDR_W'(OFS_AUTOCL)) rdata = DATA_W'(autocl_q);
        for (int v = 0; v < NVEC; v++) begin
            if (addr == ADDR_W'(OFS_MAP0 + MAP_STRIDE * v))
                rdata = DATA_W'(map_q[v]);
        end
    end
endmodule

// File: rtl/isc_vec_fsm.sv
module isc_vec_fsm
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic flush,
    output logic pulse,
    output logic pend
);
    vec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE: if (hit) state_d = VS_FIRE;   // T_HIT
            VS_FIRE: state_d = VS_WAIT;            // T_SENT
            VS_WAIT: if (ack) state_d = VS_IDLE;   // T_SERVICED
            default: state_d = VS_IDLE;
        endcase
        if (flush) state_d = VS_IDLE;              // T_FLUSH
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= VS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = (state_q == VS_FIRE);
        pend  = (state_q != VS_IDLE);
    end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_DB  = 4,
    parameter int NUM_DMA = 8,
    parameter int NUM_VEC = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DB-1:0]   db_evt,
    input  logic [NUM_DMA-1:0]  dma_evt,
    input  logic                multi_vec,
    input  logic [NUM_VEC-1:0]  vec_ack,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_VEC-1:0]  irq_pulse,
    output logic [NUM_VEC-1:0]  irq_pend
);
    localparam int NSRC = NUM_DB + NUM_DMA;

    logic [NSRC-1:0]              src_evt, status_q, enable_q, autocl_q, ac_kill;
    logic [NUM_VEC-1:0][NSRC-1:0] map_q;
    logic [NUM_VEC-1:0]           hit;
    logic                         flush;

    assign src_evt = {dma_evt, db_evt};

    isc_regs #(
        .NSRC(NSRC), .NVEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .src_evt(src_evt), .ac_kill(ac_kill), .status_q(status_q),
        .enable_q(enable_q), .autocl_q(autocl_q), .map_q(map_q),
        .flush(flush), .rdata(rdata)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign hit[v] = |(status_q & enable_q & map_q[v]);
        isc_vec_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .hit(hit[v]), .ack(vec_ack[v]),
            .flush(flush), .pulse(irq_pulse[v]), .pend(irq_pend[v])
        );
    end

    // Auto-clear acts only with several vectors in use
    always_comb begin
        ac_kill = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (multi_vec && irq_pulse[v])
                ac_kill = ac_kill | (map_q[v] & autocl_q);
        end
    end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk
    import isc_pkg::*;
#(
    parameter int NSRC   = 12,
    parameter int NVEC   = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [NVEC-1:0]   vec_ack,
    input logic [NVEC-1:0]   irq_pulse,
    input logic [NVEC-1:0]   irq_pend,
    input logic [NSRC-1:0]   src_evt,
    input logic [NSRC-1:0]   status_q
);
    logic flush_wr, stat_wr;
    assign flush_wr = wr_en && (addr == ADDR_W'(OFS_FLUSH)) && wdata[0];
    assign stat_wr  = wr_en && (addr == ADDR_W'(OFS_STATUS));

    // R2 R5
    evt_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((status_q & $past(src_evt)) == $past(src_evt)));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status_q & $past(wdata[NSRC-1:0]) & ~$past(src_evt)) == '0));

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (irq_pend == '0));

    for (genvar v = 0; v < NVEC; v++) begin : g_v
        // R6
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[v] |=> !irq_pulse[v]);
        // R6
        pulse_then_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pulse[v] && !flush_wr) |=> irq_pend[v]);
        // R7
        ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend[v] && !irq_pulse[v] && vec_ack[v]) |=> !irq_pend[v]);
    end
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
    .NSRC(NSRC), .NVEC(NUM_VEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .vec_ack(vec_ack), .irq_pulse(irq_pulse), .irq_pend(irq_pend),
    .src_evt(src_evt), .status_q(status_q)
);

// File: tb/test_irq_src_ctrl.sv
module test_irq_src_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [7:0] A_STAT = 8'h00, A_EN = 8'h04, A_ENCLR = 8'h08,
                           A_AC = 8'h0C, A_FLUSH = 8'h10, A_MAP0 = 8'h40,
                           A_MAP1 = 8'h44, A_HOLE = 8'h30;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  db_evt = '0;
    logic [7:0]  dma_evt = '0;
    logic        multi_vec = 1'b0;
    logic [3:0]  vec_ack = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_pulse, irq_pend;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_src_ctrl i_irq_src_ctrl (
        .clk(clk), .rst_n(rst_n), .db_evt(db_evt), .dma_evt(dma_evt),
        .multi_vec(multi_vec), .vec_ack(vec_ack), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse), .irq_pend(irq_pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic evt(input logic [3:0] db, input logic [7:0] dma);
        db_evt = db; dma_evt = dma;
        @(negedge clk);
        db_evt = '0; dma_evt = '0;
    endtask

    task automatic tidy();
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_FLUSH, 32'h1);
    endtask

    task automatic t_reset();
        rd("R1 status", A_STAT, 0);
        rd("R1 enable", A_EN, 0);
        rd("R1 autoclr", A_AC, 0);
        rd("R1 map0", A_MAP0, 0);
        chk("R1 pulse", {28'h0, irq_pulse}, 0);
        chk("R1 pend", {28'h0, irq_pend}, 0);
    endtask

    task automatic t_layout();
        evt(4'b0100, 8'b0010_0000);
        rd("R2 layout", A_STAT, 32'h204);
        chk("R2 no pend when masked", {28'h0, irq_pend}, 0);
    endtask

    task automatic t_w1c();
        wr(A_STAT, 32'h004);
        rd("R4 partial clear", A_STAT, 32'h200);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd("R4 full clear", A_STAT, 0);
    endtask

    task automatic t_race();
        evt(4'b0001, 8'h0);
        db_evt = 4'b0001; wr_en = 1'b1; addr = A_STAT; wdata = 32'h1;
        @(negedge clk);
        db_evt = '0; wr_en = 1'b0;
        rd("R5 event wins", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
    endtask

    task automatic t_enable();
        wr(A_EN, 32'hFFFF_FFFF);
        rd("R3 enable rw", A_EN, 32'hFFF);
        wr(A_ENCLR, 32'h00F);
        rd("R3 enable clear", A_EN, 32'hFF0);
        rd("R3 enclr reads 0", A_ENCLR, 0);
    endtask

    task automatic t_vector();
        wr(A_EN, 32'h011);
        wr(A_MAP0, 32'h001);
        wr(A_MAP1, 32'h0F0);
        evt(4'b0001, 8'h0);
        chk("R6 no pulse yet", {28'h0, irq_pulse}, 0);
        @(negedge clk);
        chk("R6 pulse v0 only", {28'h0, irq_pulse}, 32'h1);
        @(negedge clk);
        chk("R6 pulse one cycle", {28'h0, irq_pulse}, 0);
        chk("R6 pending", {28'h0, irq_pend}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R6 no repeat while pending", {28'h0, irq_pulse}, 0);
        vec_ack = 4'b0001;
        @(negedge clk);
        vec_ack = '0;
        chk("R7 ack releases", {28'h0, irq_pend}, 0);
        @(negedge clk);
        chk("R7 refire on live source", {28'h0, irq_pulse}, 32'h1);
        @(negedge clk);
        wr(A_FLUSH, 32'h1);
        chk("R10 flush clears pend", {28'h0, irq_pend}, 0);
        @(negedge clk);
        chk("R10 refire after flush", {28'h0, irq_pulse}, 32'h1);
        tidy();
        evt(4'h0, 8'h01);
        @(negedge clk);
        chk("R6 dma source to v1", {28'h0, irq_pulse}, 32'h2);
        tidy();
    endtask

    task automatic t_autoclr();
        wr(A_AC, 32'h001);
        rd("R8 autoclr rw", A_AC, 32'h1);
        multi_vec = 1'b1;
        evt(4'b0001, 8'h0);
        @(negedge clk);
        chk("R8 pulse", {28'h0, irq_pulse}, 32'h1);
        @(negedge clk);
        rd("R8 autoclear multi", A_STAT, 0);
        tidy();
        multi_vec = 1'b0;
        evt(4'b0001, 8'h0);
        @(negedge clk);
        chk("R9 pulse", {28'h0, irq_pulse}, 32'h1);
        @(negedge clk);
        rd("R9 no autoclear single", A_STAT, 32'h1);
        tidy();
    endtask

    task automatic t_map();
        wr(A_MAP1, 32'hFFFF_FFFF);
        rd("R11 map width", A_MAP1, 32'hFFF);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd("R11 hole reads 0", A_HOLE, 0);
        rd("R11 map0 kept", A_MAP0, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_w1c();
        t_race();
        t_enable();
        t_vector();
        t_autoclr();
        t_map();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule